// File: doc/BRIEF.md
# I2C Byte-Memory Target

This block lets an I2C controller read and write a small on-chip byte array. Both bus lines are brought into the system clock domain through flop synchronizers, and the block runs entirely on that faster clock, recognising bus conditions and SCL edges from the synchronized samples. The block answers to one fixed 7-bit device address. A controller first loads a word address of one or two bytes. It then either streams data bytes into the array or, after a repeated start, streams stored bytes back out.

SDA is never driven high. The block presents a single enable that, when set, pulls the line low; an external open-drain pad or the board pull-up provides the high level. There is no clock stretching, so each byte is written or fetched within the SCL low time that follows the relevant edge. Data moves only through the bus protocol. The block has no parallel data port, so it has no valid/ready interface and no back-pressure.

Top module: `i2c_mem_target`

## Requirements
- R1: While reset is asserted, and while the bus stays idle (SCL and SDA both high) after reset, `sda_pull` is 0.
- R2: A falling SDA while SCL is high starts a transfer. A rising SDA while SCL is high ends it. After an end condition `sda_pull` is 0, and the block waits for a new start, even if the end condition arrives part way through the address phase.
- R3: The first byte after a start is received MSB first. Its upper seven bits are the device address and its lowest bit selects the direction (1 = read, 0 = write). On a match, the block pulls SDA low for the whole ninth clock. During the eight data clocks of a received byte, it never pulls.
- R4: If the device address does not match, the ninth clock is left high (not acknowledged), SDA stays released, and all following bytes are ignored until the next start. The array contents and the word address are unchanged.
- R5: In a write transfer, the word address follows the device byte. With `ADDR_BYTES` = 2 it is two bytes, high byte first, and with `ADDR_BYTES` = 1 it is one byte. Each address byte is acknowledged. The address is reduced modulo `MEM_DEPTH`.
- R6: Every byte received after the word address is stored at the current word address and acknowledged. Writing continues byte after byte until a stop or start.
- R7: In a read transfer, the byte at the current word address is shifted out MSB first. SDA is released during the controller's acknowledge clock. A low acknowledge causes the next byte to be sent. A high acknowledge ends the read and leaves SDA released.
- R8: A repeated start keeps the word address. A write-direction address load followed by a repeated start with the read bit set therefore reads from the loaded address.
- R9: The word address advances by one after every byte stored or sent. It wraps from `MEM_DEPTH`-1 to 0. A read that begins with no address phase continues from where the last transfer left off.
- R10: `sda_pull` changes only after a synchronized SCL falling edge. SDA therefore never moves while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level as seen at the pad |
| sda_i | input | 1 | SDA level as seen at the pad (wired-AND of all drivers) |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Two functions meet in the same acknowledge slot. The first is the increment of the word address at the top of the array. The second is the prefetch of the next read byte, which is triggered by the controller's low acknowledge. A long fill that runs past the last location, and random bursts that start near the top, make the wrap happen in the same ack cycle as a load or a store. The bench judges every returned byte, and every byte read after the wrap with no new address, against a reference array and pointer kept in the bench. A stop in the middle of the address phase and a mismatched device address are also placed directly in front of reads, to show that neither disturbs the pointer.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[STAGES-2:0], sda_i};
      scl_d  <= scl_sy[STAGES-1];
      sda_d  <= sda_sy[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sy[STAGES-1];
  assign sda_lvl   = sda_sy[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_byte_store.sv
module i2c_byte_store #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_BYTES  = 2,
  parameter int         MEM_DEPTH   = 256,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull
);
  localparam int AW = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  phase_t        phase;
  logic [3:0]    bit_cnt;
  logic          in_ack, rd_mode, nack_seen, abyte_idx;
  logic [7:0]    shreg, txsh, hi_byte;
  logic [AW-1:0] ptr;
  logic [7:0]    rdata;
  logic [15:0]   word_in;
  logic          mem_we, byte_end, last_abyte;

  assign byte_end   = scl_fall && !in_ack && (bit_cnt == 4'd8);
  assign mem_we     = byte_end && (phase == PH_WDATA);
  assign word_in    = (ADDR_BYTES == 2) ? {hi_byte, shreg} : {8'h00, shreg};
  assign last_abyte = (ADDR_BYTES == 1) || abyte_idx;

  i2c_byte_store #(.DEPTH(MEM_DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rdata)
  );

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    if (32'(p) == MEM_DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      in_ack    <= 1'b0;
      rd_mode   <= 1'b0;
      nack_seen <= 1'b0;
      abyte_idx <= 1'b0;
      shreg     <= '0;
      txsh      <= '0;
      hi_byte   <= '0;
      ptr       <= '0;
      sda_pull  <= 1'b0;
    end else if (start_det) begin
      phase    <= PH_DEV;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      sda_pull <= 1'b0;
    end else if (phase != PH_IDLE && phase != PH_SKIP) begin
      if (scl_rise) begin
        if (!in_ack && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (in_ack && phase == PH_RDATA) begin
          nack_seen <= sda_lvl;
        end
      end else if (byte_end) begin
        in_ack <= 1'b1;
        case (phase)
          PH_DEV: begin
            if (shreg[7:1] == DEV_ADDR) begin
              sda_pull <= 1'b1;
              rd_mode  <= shreg[0];
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_WADDR: begin
            sda_pull <= 1'b1;
            if (last_abyte) ptr <= AW'(32'(word_in) % MEM_DEPTH);
            else            hi_byte <= shreg;
          end
          PH_WDATA: begin
            sda_pull <= 1'b1;
            ptr      <= step(ptr);
          end
          default: sda_pull <= 1'b0;
        endcase
      end else if (scl_fall && in_ack) begin
        in_ack  <= 1'b0;
        bit_cnt <= '0;
        case (phase)
          PH_DEV: begin
            if (rd_mode) begin
              phase    <= PH_RDATA;
              txsh     <= rdata;
              sda_pull <= ~rdata[7];
              ptr      <= step(ptr);
            end else begin
              phase     <= PH_WADDR;
              abyte_idx <= 1'b0;
              sda_pull  <= 1'b0;
            end
          end
          PH_WADDR: begin
            sda_pull <= 1'b0;
            if (last_abyte) phase <= PH_WDATA;
            else            abyte_idx <= 1'b1;
          end
          PH_RDATA: begin
            if (nack_seen) begin
              phase    <= PH_SKIP;
              sda_pull <= 1'b0;
            end else begin
              txsh     <= rdata;
              sda_pull <= ~rdata[7];
              ptr      <= step(ptr);
            end
          end
          default: sda_pull <= 1'b0;
        endcase
      end else if (scl_fall && phase == PH_RDATA) begin
        txsh     <= txsh << 1;
        sda_pull <= ~txsh[6];
      end
    end
  end

  assert_pull_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> $past(scl_fall));

  assert_skip_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !sda_pull);

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull && phase == PH_IDLE));

  assert_rx_bits_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_DEV || phase == PH_WADDR || phase == PH_WDATA) && !in_ack) |-> !sda_pull);

  assert_bitcnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8);
endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
  localparam int Q = 4;
  localparam logic [6:0] DEV = 7'h50;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_pull;
  logic sda_bus;
  int   errors = 0;
  int   checks = 0;
  logic [7:0] ref_mem [DEPTH];
  int   ref_ptr = 0;
  logic [7:0] wbuf [8];
  logic prev_pull = 1'b0;
  int   high_moves = 0;
  logic pull_seen = 1'b0;

  assign sda_bus = sda_drv & ~sda_pull;

  always #2.5 clk = ~clk;

  i2c_mem_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus), .sda_pull(sda_pull)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_pull !== prev_pull && scl_drv) high_moves++;
      if (sda_pull) pull_seen = 1'b1;
    end
    prev_pull = sda_pull;
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p + 1) % DEPTH;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_drv = 1'b1; hold(Q);
    scl_drv = 1'b1; hold(Q);
    sda_drv = 1'b0; hold(Q);
    scl_drv = 1'b0; hold(2);
  endtask

  task automatic bus_stop;
    sda_drv = 1'b0; hold(Q);
    scl_drv = 1'b1; hold(Q);
    sda_drv = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; hold(Q);
      scl_drv = 1'b1; hold(2*Q);
      scl_drv = 1'b0; hold(2);
    end
    sda_drv = 1'b1; hold(Q);
    scl_drv = 1'b1; hold(Q);
    acked = (sda_bus == 1'b0);
    hold(Q);
    scl_drv = 1'b0; hold(2);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    sda_drv = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      hold(Q);
      scl_drv = 1'b1; hold(Q);
      d = {d[6:0], sda_bus};
      hold(Q);
      scl_drv = 1'b0; hold(2);
    end
    sda_drv = nack; hold(Q);
    scl_drv = 1'b1; hold(2*Q);
    scl_drv = 1'b0; hold(2);
    sda_drv = 1'b1;
  endtask

  task automatic addr_phase(input logic [15:0] wa);
    bit a;
    bus_start;
    send_byte({DEV, 1'b0}, a);
    chk(a, "R3 device write ack", a, 1);
    send_byte(wa[15:8], a);
    chk(a, "R5 address high ack", a, 1);
    send_byte(wa[7:0], a);
    chk(a, "R5 address low ack", a, 1);
    ref_ptr = wa % DEPTH;
  endtask

  task automatic write_txn(input logic [15:0] wa, input int n);
    bit a;
    addr_phase(wa);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a);
      chk(a, "R6 data ack", a, 1);
      ref_mem[ref_ptr] = wbuf[i];
      ref_ptr = nxt(ref_ptr);
    end
    bus_stop;
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      chk(d === ref_mem[ref_ptr], tag, d, ref_mem[ref_ptr]);
      ref_ptr = nxt(ref_ptr);
    end
    hold(Q);
    chk(sda_pull == 1'b0, "R7 released after nack", sda_pull, 0);
    bus_stop;
  endtask

  task automatic rand_read(input logic [15:0] wa, input int n);
    bit a;
    addr_phase(wa);
    bus_start;
    send_byte({DEV, 1'b1}, a);
    chk(a, "R8 device read ack after repeated start", a, 1);
    read_body(n, "R8 R7 random read data");
  endtask

  task automatic cur_read(input int n);
    bit a;
    bus_start;
    send_byte({DEV, 1'b1}, a);
    chk(a, "R3 device read ack", a, 1);
    read_body(n, "R9 current-address read data");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary;
    $finish;
  end

  initial begin
    bit a;
    int n;
    logic [15:0] wa;
    void'($urandom(32'd1234));
    hold(3);
    chk(sda_pull == 1'b0, "R1 pull low in reset", sda_pull, 0);
    rst_n = 1'b1;
    hold(20);
    chk(sda_pull == 1'b0, "R1 idle bus released", sda_pull, 0);

    // R9: fill whole array starting near the top so the pointer wraps
    addr_phase(16'h12F0);
    for (int i = 0; i < DEPTH + 4; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      send_byte(v, a);
      if (i % 64 == 0 || i > DEPTH - 20) chk(a, "R6 fill ack", a, 1);
      ref_mem[ref_ptr] = v;
      ref_ptr = nxt(ref_ptr);
    end
    bus_stop;
    chk(sda_pull == 1'b0, "R2 released after stop", sda_pull, 0);

    // R9: read across the top with wrap, then continue without address
    rand_read(16'h00FD, 5);
    cur_read(3);

    // R4: mismatched device address, bytes that follow are ignored
    pull_seen = 1'b0;
    bus_start;
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    chk(!a, "R4 mismatch not acknowledged", a, 0);
    send_byte(8'h00, a);
    send_byte(8'h05, a);
    send_byte(8'hC3, a);
    bus_stop;
    chk(!pull_seen, "R4 SDA never pulled when unaddressed", pull_seen, 0);
    cur_read(1);
    rand_read(16'h0005, 1);

    // R2: stop inside the address phase, then normal operation
    bus_start;
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h00, a);
    bus_stop;
    hold(Q);
    chk(sda_pull == 1'b0, "R2 released after mid-address stop", sda_pull, 0);
    cur_read(2);

    // random write/read bursts
    for (int t = 0; t < 14; t++) begin
      wa = 16'($urandom);
      if (t % 4 == 0) wa[7:0] = 8'hFE;
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_txn(wa, n);
      rand_read(wa, n);
      cur_read(1);
    end

    chk(high_moves == 0, "R10 pull changed while SCL high", high_moves, 0);
    summary;
    $finish;
  end
endmodule